// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block watches each bus cycle and compares it against a small set of programmable windows. A window is described by a base register and an option register. The base register gives a base address and a power-of-two block size. The option register gives the address space, the interrupt level, the transfer direction, the byte lanes, the port width and a wait-state code. When a cycle falls inside an enabled window, the block pulls that window's active-low select line low. After the programmed number of wait states it raises the acknowledge for an 8-bit or a 16-bit port. It can instead terminate the cycle fast, or tell external logic to supply the acknowledge itself.

Each select pin also has a 2-bit assignment. The assignment makes the pin a chip select, parks it high for an alternate bus function, or drives it as a general output from a port data register. Window 0 is the boot window. It comes out of reset already enabled and covering the bottom of memory, so code can be fetched before any register has been written.

Top module: `csel_wait_gen`

## Requirements
- R1: After reset, window 0 decodes base 0 with a 512 KB block in both supervisor and user space, reads and writes, both bytes, 16-bit port and wait code 13. Its pin is a chip select. All other pins are in alternate mode, so every select output is high and no acknowledge is active.
- R2: The base register holds address bits 23:11 in bits 15:3 and the size code in bits 2:0. Size codes 0 to 7 give 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes. Address bits below the block size are not compared.
- R3: The option register holds the space field in bits 4:3. Value 0 matches CPU space (function code 7). Value 1 matches user space (function code bit 2 clear). Value 2 matches supervisor space (function code bit 2 set, function code not 7). Value 3 matches any space except CPU space.
- R4: Option bits 2:0 give an interrupt level. It applies only to a space-0 window, which matches only interrupt-acknowledge cycles: function code 7 with address bits 19:16 all ones. Level 0 accepts any acknowledged level; levels 1 to 7 accept only that exact level. No base-address comparison is made for such a window.
- R5: Option bits 12:11 select byte lanes: 0 disabled, 1 lower, 2 upper, 3 both. A cycle touches the upper byte when address bit 0 is 0. It touches the lower byte when address bit 0 is 1 or the size code is not 01 (byte).
- R6: Option bits 10:9 select the direction: bit 9 allows reads (rw=1) and bit 10 allows writes (rw=0).
- R7: Option bits 8:5 hold the wait code. A code W from 0 to 13 raises the acknowledge W+1 clock edges after the first edge that sees the strobe low. Code 14 raises it on that first edge, together with the select. Code 15 raises `ack_ext` on that edge and never raises an acknowledge. At most one of the three acknowledge outputs is high.
- R8: Option bit 13 set makes the acknowledge appear on `ack_word` (16-bit port); clear makes it appear on `ack_byte`.
- R9: Pin assignment codes are 2 and 3 for chip select, 1 for alternate (output held high) and 0 for discrete output (output equals that pin's port data bit). A window whose pin is not a chip select never selects or acknowledges.
- R10: When several windows match, all of their selects go low. Wait code and port width come from the lowest-numbered matching window.
- R11: Selects and acknowledges are held while the strobe stays low. They are cleared at the first clock edge that sees the strobe high.
- R12: Register writes with `cfg_we` high use `cfg_kind` 0 for base, 1 for option and 2 for pin assignment, each at window `cfg_idx`. Kind 3 writes the port data bits from `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function code (address space) |
| rw | input | 1 | 1 read, 0 write |
| siz | input | 2 | Transfer size, 01 byte |
| iack_lvl | input | 3 | Interrupt level being acknowledged |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | Register kind select |
| cfg_idx | input | 2 | Window index |
| cfg_wdata | input | 16 | Register write data |
| cs_n | output | 4 | Select outputs, active low |
| ack_byte | output | 1 | Acknowledge, 8-bit port |
| ack_word | output | 1 | Acknowledge, 16-bit port |
| ack_ext | output | 1 | External logic must acknowledge |

## Verification
Four windows are set up with different spaces, sizes, byte lanes, directions and wait codes. Each window is then hit at its first and last address and just past its end, so a wrong size mask shows up as a select on the outside address. The same address is also driven with the wrong space, direction or byte lane, which separates the space, direction and lane qualifiers from one another.

Interrupt-acknowledge cycles at the programmed level and at another level test the level match. The bench counts the edges until the acknowledge appears for wait codes 0, 2 and 13, for fast termination and for the external code. An overlapping window pair tests the priority. Pin reassignment is checked at the select outputs while no bus cycle is running.

// File: rtl/csel_wait_gen.sv
module csel_wait_gen #(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int DW  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           as_n,
  input  logic [AW-1:0]                  addr,
  input  logic [2:0]                     fc,
  input  logic                           rw,
  input  logic [1:0]                     siz,
  input  logic [2:0]                     iack_lvl,
  input  logic                           cfg_we,
  input  logic [1:0]                     cfg_kind,
  input  logic [(NCS>1?$clog2(NCS):1)-1:0] cfg_idx,
  input  logic [DW-1:0]                  cfg_wdata,
  output logic [NCS-1:0]                 cs_n,
  output logic                           ack_byte,
  output logic                           ack_word,
  output logic                           ack_ext
);
  localparam int LSB = 11;
  localparam int BW  = AW - LSB;
  localparam int OW  = 14;
  localparam logic [DW-1:0] BOOT_BASE = {{(DW-3){1'b0}}, 3'b110};
  localparam logic [OW-1:0] BOOT_OPT  = {1'b1, 2'b11, 2'b11, 4'd13, 2'b11, 3'b000};

  logic [DW-1:0]  base_r [NCS];
  logic [OW-1:0]  opt_r  [NCS];
  logic [1:0]     pin_r  [NCS];
  logic [NCS-1:0] port_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) begin
        base_r[i] <= (i == 0) ? BOOT_BASE : '0;
        opt_r[i]  <= (i == 0) ? BOOT_OPT : '0;
        pin_r[i]  <= (i == 0) ? 2'b10 : 2'b01;
      end
      port_r <= '1;
    end else if (cfg_we) begin
      case (cfg_kind)
        2'd0:    base_r[cfg_idx] <= cfg_wdata;
        2'd1:    opt_r[cfg_idx]  <= cfg_wdata[OW-1:0];
        2'd2:    pin_r[cfg_idx]  <= cfg_wdata[1:0];
        default: port_r          <= cfg_wdata[NCS-1:0];
      endcase
    end
  end

  wire cpu_sp   = (fc == 3'b111);
  wire iack_cyc = cpu_sp && (addr[19:16] == 4'hF);
  wire upper_t  = ~addr[0];
  wire lower_t  = addr[0] | (siz != 2'b01);

  logic [NCS-1:0] hit;

  for (genvar g = 0; g < NCS; g++) begin : g_win
    logic [4:0]    sb;
    logic          byte_ok, sp_ok;
    logic [1:0]    sp;
    logic [2:0]    lvl;
    logic [AW-1:0] amask, bfull;

    always_comb begin
      case (base_r[g][2:0])
        3'd0:    sb = 5'd11;
        3'd1:    sb = 5'd13;
        3'd2:    sb = 5'd14;
        3'd3:    sb = 5'd16;
        3'd4:    sb = 5'd17;
        3'd5:    sb = 5'd18;
        3'd6:    sb = 5'd19;
        default: sb = 5'd20;
      endcase
    end

    assign amask = {AW{1'b1}} << sb;
    assign bfull = {base_r[g][BW+2:3], {LSB{1'b0}}};
    assign sp    = opt_r[g][4:3];
    assign lvl   = opt_r[g][2:0];

    always_comb begin
      case (opt_r[g][12:11])
        2'b00:   byte_ok = 1'b0;
        2'b01:   byte_ok = lower_t;
        2'b10:   byte_ok = upper_t;
        default: byte_ok = 1'b1;
      endcase
      case (sp)
        2'b00:   sp_ok = iack_cyc && (lvl == 3'd0 || lvl == iack_lvl);
        2'b01:   sp_ok = ~fc[2];
        2'b10:   sp_ok = fc[2] && !cpu_sp;
        default: sp_ok = !cpu_sp;
      endcase
    end

    assign hit[g] = pin_r[g][1] && byte_ok && sp_ok
                 && (rw ? opt_r[g][9] : opt_r[g][10])
                 && ((sp == 2'b00) || (((addr ^ bfull) & amask) == '0));

    assign cs_n[g] = pin_r[g][1] ? ~sel_q[g] : (pin_r[g][0] ? 1'b1 : port_r[g]);
  end

  logic [3:0] pk_dack;
  logic       pk_p16;

  always_comb begin
    pk_dack = 4'd0;
    pk_p16  = 1'b0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pk_dack = opt_r[i][8:5];
        pk_p16  = opt_r[i][13];
      end
    end
  end

  logic [NCS-1:0] sel_q;
  logic           busy, waiting, ack_q, ext_q, p16_q;
  logic [3:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; busy <= 1'b0; waiting <= 1'b0; cnt <= '0;
      ack_q <= 1'b0; ext_q <= 1'b0; p16_q <= 1'b0;
    end else if (as_n) begin
      sel_q <= '0; busy <= 1'b0; waiting <= 1'b0;
      ack_q <= 1'b0; ext_q <= 1'b0;
    end else if (!busy) begin
      busy  <= 1'b1;
      sel_q <= hit;
      if (|hit) begin
        p16_q <= pk_p16;
        case (pk_dack)
          4'hE:    ack_q <= 1'b1;
          4'hF:    ext_q <= 1'b1;
          default: begin cnt <= pk_dack; waiting <= 1'b1; end
        endcase
      end
    end else if (waiting) begin
      if (cnt == 4'd0) begin
        ack_q   <= 1'b1;
        waiting <= 1'b0;
      end else begin
        cnt <= cnt - 4'd1;
      end
    end
  end

  assign ack_byte = ack_q & ~p16_q;
  assign ack_word = ack_q & p16_q;
  assign ack_ext  = ext_q;

  // R11
  sel_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_q) |-> $past(!as_n));

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (sel_q == '0 && !ack_byte && !ack_word && !ack_ext));

  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_byte, ack_word, ack_ext}));

  // R7
  ack_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_byte || ack_word || ack_ext) |-> (|sel_q));

endmodule

// File: tb/csel_wait_gen_tb.sv
module csel_wait_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_n = 1'b1;
  logic [23:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        rw = 1'b1;
  logic [1:0]  siz = 2'b10;
  logic [2:0]  iack_lvl = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  cs_n;
  logic        ack_byte, ack_word, ack_ext;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  csel_wait_gen dut_i (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .fc(fc), .rw(rw),
    .siz(siz), .iack_lvl(iack_lvl), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cs_n(cs_n),
    .ack_byte(ack_byte), .ack_word(ack_word), .ack_ext(ack_ext));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [23:0] a;
    logic [2:0]  f;
    logic        r;
    logic [1:0]  s;
    logic [2:0]  l;
    logic [3:0]  cs;
    logic [1:0]  kd;
    logic [4:0]  dl;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{24'h100000, 3'd1, 1'b1, 2'b10, 3'd0, 4'hD, 2'd1, 5'd3},  // R2 R6 R7 R8
    '{24'h10FFFE, 3'd1, 1'b1, 2'b10, 3'd0, 4'hD, 2'd1, 5'd3},  // R2
    '{24'h110000, 3'd1, 1'b1, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0},  // R2
    '{24'h100000, 3'd1, 1'b0, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0},  // R6
    '{24'h100000, 3'd5, 1'b1, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0},  // R3
    '{24'h200000, 3'd5, 1'b1, 2'b01, 3'd0, 4'hB, 2'd2, 5'd0},  // R5 R7
    '{24'h200001, 3'd5, 1'b1, 2'b01, 3'd0, 4'hF, 2'd0, 5'd0},  // R5
    '{24'h2007FE, 3'd5, 1'b0, 2'b10, 3'd0, 4'hB, 2'd2, 5'd0},  // R2 R5 R6
    '{24'h200800, 3'd5, 1'b1, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0},  // R2
    '{24'h200000, 3'd1, 1'b1, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0},  // R3
    '{24'hFFFFFB, 3'd7, 1'b1, 2'b01, 3'd5, 4'h7, 2'd3, 5'd0},  // R4 R7
    '{24'hFFFFF7, 3'd7, 1'b1, 2'b01, 3'd3, 4'hF, 2'd0, 5'd0},  // R4
    '{24'h020000, 3'd7, 1'b1, 2'b01, 3'd5, 4'hF, 2'd0, 5'd0},  // R3 R4
    '{24'h07FFFE, 3'd6, 1'b1, 2'b10, 3'd0, 4'hE, 2'd2, 5'd14}, // R1 R8
    '{24'h000100, 3'd1, 1'b1, 2'b10, 3'd0, 4'hE, 2'd2, 5'd14}  // R3
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] k, input logic [1:0] i, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] opt(input bit p16, input logic [1:0] byt, input logic [1:0] rwf,
                                      input logic [3:0] dk, input logic [1:0] sp, input logic [2:0] lv);
    return {2'b00, p16, byt, rwf, dk, sp, lv};
  endfunction

  task automatic run(input vec_t v, input logic [3:0] idle, input string req);
    int n;
    bit bad;
    @(negedge clk);
    addr = v.a; fc = v.f; rw = v.r; siz = v.s; iack_lvl = v.l; as_n = 1'b0;
    @(negedge clk);
    chk(cs_n == v.cs, {req, " select"}, cs_n, v.cs);
    if (v.kd == 2'd1 || v.kd == 2'd2) begin
      n = 0;
      while (!(ack_byte || ack_word) && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk(n == v.dl, {req, " wait"}, n, v.dl);
      chk({ack_word, ack_byte} == ((v.kd == 2'd2) ? 2'b10 : 2'b01), {req, " width"},
          {ack_word, ack_byte}, (v.kd == 2'd2) ? 2'b10 : 2'b01);
      @(negedge clk);
      chk(cs_n == v.cs && (ack_byte || ack_word), {req, " R11 hold"}, cs_n, v.cs);
    end else begin
      chk(ack_ext == (v.kd == 2'd3) && !ack_byte && !ack_word, {req, " ack"},
          {ack_ext, ack_word, ack_byte}, {v.kd == 2'd3, 2'b00});
      bad = 1'b0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (ack_byte || ack_word || ack_ext != (v.kd == 2'd3)) bad = 1'b1;
      end
      chk(!bad, {req, " no ack"}, bad, 0);
    end
    as_n = 1'b1;
    @(negedge clk);
    chk(cs_n == idle && !ack_byte && !ack_word && !ack_ext, {req, " R11 release"},
        {ack_ext, ack_word, ack_byte, cs_n}, {3'b000, idle});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && !ack_byte && !ack_word && !ack_ext, "R1 reset", {ack_ext, ack_word, ack_byte, cs_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 after reset", cs_n, 4'hF);
    run('{24'h000000, 3'd6, 1'b1, 2'b10, 3'd0, 4'hE, 2'd2, 5'd14}, 4'hF, "R1 boot");
    run('{24'h080000, 3'd6, 1'b1, 2'b10, 3'd0, 4'hF, 2'd0, 5'd0}, 4'hF, "R1 R2 boot edge");

    // R12 programming
    cfg(2'd0, 2'd1, 16'h1003);
    cfg(2'd1, 2'd1, opt(1'b0, 2'b11, 2'b01, 4'd2, 2'b01, 3'd0));
    cfg(2'd2, 2'd1, 16'h0002);
    cfg(2'd0, 2'd2, 16'h2000);
    cfg(2'd1, 2'd2, opt(1'b1, 2'b10, 2'b11, 4'hE, 2'b10, 3'd0));
    cfg(2'd2, 2'd2, 16'h0003);
    cfg(2'd0, 2'd3, 16'h0000);
    cfg(2'd1, 2'd3, opt(1'b1, 2'b11, 2'b11, 4'hF, 2'b00, 3'd5));
    cfg(2'd2, 2'd3, 16'h0002);

    for (int i = 0; i < NV; i++) run(VECS[i], 4'hF, $sformatf("vec%0d", i));

    // R10 overlap with boot window
    cfg(2'd0, 2'd1, 16'h0000);
    run('{24'h000010, 3'd1, 1'b1, 2'b10, 3'd0, 4'hC, 2'd2, 5'd14}, 4'hF, "R10 priority");

    // R7 wait code zero
    cfg(2'd0, 2'd1, 16'h1003);
    cfg(2'd1, 2'd1, opt(1'b0, 2'b11, 2'b01, 4'd0, 2'b01, 3'd0));
    run('{24'h100000, 3'd1, 1'b1, 2'b10, 3'd0, 4'hD, 2'd1, 5'd1}, 4'hF, "R7 zero wait");

    // R5 lanes disabled
    cfg(2'd1, 2'd2, opt(1'b1, 2'b00, 2'b11, 4'hE, 2'b10, 3'd0));
    run('{24'h200000, 3'd5, 1'b1, 2'b01, 3'd0, 4'hF, 2'd0, 5'd0}, 4'hF, "R5 disabled");

    // R9 discrete and alternate pins
    cfg(2'd2, 2'd3, 16'h0000);
    cfg(2'd3, 2'd0, 16'h0007);
    @(negedge clk);
    chk(cs_n == 4'h7, "R9 discrete low", cs_n, 4'h7);
    run('{24'hFFFFFB, 3'd7, 1'b1, 2'b01, 3'd5, 4'h7, 2'd0, 5'd0}, 4'h7, "R9 discrete no ack");
    cfg(2'd3, 2'd0, 16'h000F);
    @(negedge clk);
    chk(cs_n == 4'hF, "R9 discrete high", cs_n, 4'hF);
    cfg(2'd3, 2'd0, 16'h0000);
    cfg(2'd2, 2'd3, 16'h0001);
    @(negedge clk);
    chk(cs_n == 4'hF, "R9 alternate", cs_n, 4'hF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule